// File: doc/BRIEF.md
# Debug Transmit Channel with Privilege Trap Check

This block is the transmit half of a core-to-debugger mailbox. The core writes a 32-bit word into a 64-bit transmit register, and an external debugger drains it. A full flag tells the debugger that a word is waiting. A read by the debugger returns the word, zero-extended to 64 bits, and empties the mailbox.

A core write is not always allowed. The block checks it against the current privilege level (0 to 3), a halted flag and a set of static trap-control inputs. The checks run in a fixed priority order and produce one of two results:

- **Accepted:** the word is stored and the full flag is set.
- **Trapped:** the write is refused. The block pulses a trap indication for one cycle, carrying a 2-bit target level and the syndrome class 0x18.

Exception entry itself is handled outside this block.

Top module: `dbg_tx_chan`

## Requirements
- R1: While reset is active and after it is released, tx_full reads 0, dbg_rd_data reads 0 and trap_vld reads 0.
- R2: An accepted core write stores core_wr_data[31:0]. From the next cycle, tx_full is 1, dbg_rd_data[31:0] holds the stored word and dbg_rd_data[63:32] is 0. Bits 63:32 of the write data are discarded.
- R3: When core_halted is 1, a write is always accepted and never traps, at any level and with any trap settings.
- R4: At level 0 with cfg_user_trap set, the write traps. The target is level 2 when cfg_el2_en and cfg_host_redir are both 1, and level 1 otherwise.
- R5: At level 0 with cfg_user_trap clear and cfg_el2_en set, the write traps to level 2 in either of these cases:
  - cfg_l2_chan_trap is set;
  - any of cfg_host_redir, cfg_l2_dbg_route or cfg_l2_acc_trap is set.
- R6: At level 1 with cfg_el2_en set, the write traps to level 2 in either of these cases:
  - cfg_l2_chan_trap is set and cfg_fgt_has is 1;
  - cfg_l2_dbg_route or cfg_l2_acc_trap is set.
  At level 1, cfg_host_redir and cfg_user_trap have no effect.
- R7: The level-3 checks apply at level 2, and at levels 0 and 1 when no earlier check hits. With cfg_el3_has set, the write traps to level 3 in either of these cases:
  - cfg_l3_chan_trap is set and cfg_fgt_has is 1;
  - cfg_l3_acc_trap is set.
- R8: At level 3, a write is always accepted.
- R9: A trapped write sets trap_vld for exactly the one cycle after the write, with trap_lvl giving the target level and trap_class equal to 0x18. Stored data and tx_full are unchanged. When trap_vld is 0, trap_class is 0.
- R10: A debugger read (dbg_rd_en) with no accepted write in the same cycle clears tx_full on the next clock edge. The stored data is kept.
- R11: An accepted write and a debugger read in the same cycle leave tx_full at 1 and store the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr_en | input | 1 | Core write request |
| core_wr_data | input | 64 | Core write data; only bits 31:0 are stored |
| core_lvl | input | 2 | Current privilege level of the core |
| core_halted | input | 1 | Core is halted in debug state |
| cfg_el2_en | input | 1 | Level 2 is enabled |
| cfg_el3_has | input | 1 | Level 3 is present |
| cfg_fgt_has | input | 1 | Fine-grained traps are implemented |
| cfg_user_trap | input | 1 | Level-1 control: trap level-0 channel access |
| cfg_host_redir | input | 1 | Level-2 host redirect |
| cfg_l2_chan_trap | input | 1 | Level-2 channel trap |
| cfg_l2_dbg_route | input | 1 | Level-2 debug exception routing |
| cfg_l2_acc_trap | input | 1 | Level-2 debug register access trap |
| cfg_l3_chan_trap | input | 1 | Level-3 channel trap |
| cfg_l3_acc_trap | input | 1 | Level-3 debug register access trap |
| dbg_rd_en | input | 1 | Debugger read; empties the mailbox |
| dbg_rd_data | output | 64 | Stored word, zero-extended |
| tx_full | output | 1 | A word is waiting for the debugger |
| trap_vld | output | 1 | One-cycle trap indication |
| trap_lvl | output | 2 | Target level of the trap |
| trap_class | output | 6 | Syndrome class; 0x18 while trap_vld is set |

## Verification
A fault in the priority chain shows up one cycle after the offending write, in one of three ways:
- trap_vld is wrong;
- trap_lvl names the wrong target level;
- the write is accepted and dbg_rd_data changes when it should not.

The bench therefore sweeps every combination of the ten trap controls, at all four levels, both halted and running. A corrupted full flag or data register is visible on tx_full and dbg_rd_data from the very next cycle. Interleaved debugger reads, some of them in the same cycle as a write, expose wrong read-clear or collision handling within one cycle.

// File: rtl/dbg_tx_pkg.sv
package dbg_tx_pkg;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned EC_W   = 6;
  localparam logic [EC_W-1:0] EC_DBG_CHAN = 6'h18;

  typedef struct packed {
    logic el2_en;
    logic el3_has;
    logic fgt_has;
    logic user_trap;
    logic host_redir;
    logic l2_chan_trap;
    logic l2_dbg_route;
    logic l2_acc_trap;
    logic l3_chan_trap;
    logic l3_acc_trap;
  } trap_cfg_t;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] tgt;
  } trap_res_t;
endpackage

// File: rtl/dbg_tx_trap.sv
module dbg_tx_trap
  import dbg_tx_pkg::*;
(
  input  logic             halted,
  input  logic [LVL_W-1:0] lvl,
  input  trap_cfg_t        cfg,
  output trap_res_t        res
);
  trap_res_t l3_res;

  // Level-3 checks, shared by levels 0, 1 and 2
  always_comb begin
    l3_res = '0;
    if (cfg.el3_has && cfg.fgt_has && cfg.l3_chan_trap) begin
      l3_res.hit = 1'b1;
      l3_res.tgt = 2'd3;
    end else if (cfg.el3_has && cfg.l3_acc_trap) begin
      l3_res.hit = 1'b1;
      l3_res.tgt = 2'd3;
    end
  end

  always_comb begin
    res = '0;
    if (!halted) begin
      unique case (lvl)
        2'd0: begin
          if (cfg.user_trap) begin
            res.hit = 1'b1;
            res.tgt = (cfg.el2_en && cfg.host_redir) ? 2'd2 : 2'd1;
          end else if (cfg.el2_en && cfg.l2_chan_trap) begin
            res.hit = 1'b1;
            res.tgt = 2'd2;
          end else if (cfg.el2_en &&
                       (cfg.host_redir || cfg.l2_dbg_route || cfg.l2_acc_trap)) begin
            res.hit = 1'b1;
            res.tgt = 2'd2;
          end else begin
            res = l3_res;
          end
        end
        2'd1: begin
          if (cfg.el2_en && cfg.fgt_has && cfg.l2_chan_trap) begin
            res.hit = 1'b1;
            res.tgt = 2'd2;
          end else if (cfg.el2_en && (cfg.l2_dbg_route || cfg.l2_acc_trap)) begin
            res.hit = 1'b1;
            res.tgt = 2'd2;
          end else begin
            res = l3_res;
          end
        end
        2'd2: res = l3_res;
        default: res = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_tx_store.sv
module dbg_tx_store #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [DATA_W-1:0] word_q,
  output logic              full_q
);
  logic [DATA_W-1:0] word_d;
  logic              full_d;
  logic              word_en;

  always_comb begin
    word_en = wr_ok;
    word_d  = wr_word;
    full_d  = full_q;
    if (wr_ok)      full_d = 1'b1;
    else if (rd_en) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (word_en) word_q <= word_d;
    end
  end
endmodule

// File: rtl/dbg_tx_chan.sv
module dbg_tx_chan
  import dbg_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_wr_en,
  input  logic [REG_W-1:0] core_wr_data,
  input  logic [1:0]       core_lvl,
  input  logic             core_halted,
  input  logic             cfg_el2_en,
  input  logic             cfg_el3_has,
  input  logic             cfg_fgt_has,
  input  logic             cfg_user_trap,
  input  logic             cfg_host_redir,
  input  logic             cfg_l2_chan_trap,
  input  logic             cfg_l2_dbg_route,
  input  logic             cfg_l2_acc_trap,
  input  logic             cfg_l3_chan_trap,
  input  logic             cfg_l3_acc_trap,
  input  logic             dbg_rd_en,
  output logic [REG_W-1:0] dbg_rd_data,
  output logic             tx_full,
  output logic             trap_vld,
  output logic [1:0]       trap_lvl,
  output logic [5:0]       trap_class
);
  localparam int unsigned PAD_W = REG_W - DATA_W;

  // Reset: asserted asynchronously, released synchronously
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  trap_cfg_t cfg;
  trap_res_t dec;

  always_comb begin
    cfg.el2_en       = cfg_el2_en;
    cfg.el3_has      = cfg_el3_has;
    cfg.fgt_has      = cfg_fgt_has;
    cfg.user_trap    = cfg_user_trap;
    cfg.host_redir   = cfg_host_redir;
    cfg.l2_chan_trap = cfg_l2_chan_trap;
    cfg.l2_dbg_route = cfg_l2_dbg_route;
    cfg.l2_acc_trap  = cfg_l2_acc_trap;
    cfg.l3_chan_trap = cfg_l3_chan_trap;
    cfg.l3_acc_trap  = cfg_l3_acc_trap;
  end

  dbg_tx_trap u_trap (
    .halted (core_halted),
    .lvl    (core_lvl),
    .cfg    (cfg),
    .res    (dec)
  );

  logic              wr_ok;
  logic [DATA_W-1:0] word_q;

  assign wr_ok = core_wr_en && !dec.hit;

  dbg_tx_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_ok   (wr_ok),
    .wr_word (core_wr_data[DATA_W-1:0]),
    .rd_en   (dbg_rd_en),
    .word_q  (word_q),
    .full_q  (tx_full)
  );

  // Registered trap pulse
  logic       trap_vld_d;
  logic [1:0] trap_lvl_d;

  always_comb begin
    trap_vld_d = core_wr_en && dec.hit;
    trap_lvl_d = trap_vld_d ? dec.tgt : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trap_vld <= 1'b0;
      trap_lvl <= 2'd0;
    end else begin
      trap_vld <= trap_vld_d;
      trap_lvl <= trap_lvl_d;
    end
  end

  assign trap_class = trap_vld ? EC_DBG_CHAN : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign dbg_rd_data = {{PAD_W{1'b0}}, word_q};
    end else begin : g_nopad
      assign dbg_rd_data = word_q[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/dbg_tx_chan_chk.sv
module dbg_tx_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        core_wr_en,
  input logic [1:0]  core_lvl,
  input logic        core_halted,
  input logic        dbg_rd_en,
  input logic [63:0] dbg_rd_data,
  input logic        tx_full,
  input logic        trap_vld,
  input logic [1:0]  trap_lvl,
  input logic [5:0]  trap_class
);
  p_trap_follows_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> $past(core_wr_en));

  p_trap_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> trap_class == 6'h18);

  p_trap_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> dbg_rd_data == $past(dbg_rd_data));

  p_halt_no_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_wr_en && core_halted) |-> (!trap_vld && tx_full));

  p_lvl3_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_wr_en && core_lvl == 2'd3) |-> !trap_vld);

  p_trap_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> trap_lvl != 2'd0);

  p_rd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_rd_en && !core_wr_en) |-> !tx_full);

  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_rd_en && core_wr_en && core_halted) |-> tx_full);
endmodule

bind dbg_tx_chan dbg_tx_chan_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .core_wr_en  (core_wr_en),
  .core_lvl    (core_lvl),
  .core_halted (core_halted),
  .dbg_rd_en   (dbg_rd_en),
  .dbg_rd_data (dbg_rd_data),
  .tx_full     (tx_full),
  .trap_vld    (trap_vld),
  .trap_lvl    (trap_lvl),
  .trap_class  (trap_class)
);

// File: tb/dbg_tx_chan_tb.sv
module dbg_tx_chan_tb;
  logic        clk;
  logic        rst_n;
  logic        core_wr_en;
  logic [63:0] core_wr_data;
  logic [1:0]  core_lvl;
  logic        core_halted;
  logic [9:0]  cfgv;
  logic        dbg_rd_en;
  logic [63:0] dbg_rd_data;
  logic        tx_full;
  logic        trap_vld;
  logic [1:0]  trap_lvl;
  logic [5:0]  trap_class;

  // cfgv bit map used by the bench:
  // 9 el2_en, 8 el3_has, 7 fgt_has, 6 user_trap, 5 host_redir,
  // 4 l2_chan_trap, 3 l2_dbg_route, 2 l2_acc_trap, 1 l3_chan_trap, 0 l3_acc_trap
  dbg_tx_chan u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_wr_en(core_wr_en), .core_wr_data(core_wr_data),
    .core_lvl(core_lvl), .core_halted(core_halted),
    .cfg_el2_en(cfgv[9]), .cfg_el3_has(cfgv[8]), .cfg_fgt_has(cfgv[7]),
    .cfg_user_trap(cfgv[6]), .cfg_host_redir(cfgv[5]),
    .cfg_l2_chan_trap(cfgv[4]), .cfg_l2_dbg_route(cfgv[3]),
    .cfg_l2_acc_trap(cfgv[2]), .cfg_l3_chan_trap(cfgv[1]),
    .cfg_l3_acc_trap(cfgv[0]),
    .dbg_rd_en(dbg_rd_en), .dbg_rd_data(dbg_rd_data), .tx_full(tx_full),
    .trap_vld(trap_vld), .trap_lvl(trap_lvl), .trap_class(trap_class)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic        vld;
    logic [1:0]  lvl;
    logic [63:0] data;
    logic        full;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_err  = 0;
  bit   done   = 0;
  logic [31:0] m_data = '0;
  logic        m_full = 1'b0;

  // Reference trap decision: returns {hit, target}
  function automatic logic [2:0] ref_trap(input logic h, input logic [1:0] l,
                                          input logic [9:0] c, output string tag);
    logic e2 = c[9], e3 = c[8], fg = c[7];
    logic l3hit = (e3 & fg & c[1]) | (e3 & c[0]);
    tag = "R7";
    if (h)        begin tag = "R3"; return 3'b000; end
    if (l == 2'd3) begin tag = "R8"; return 3'b000; end
    if (l == 2'd0) begin
      if (c[6]) begin tag = "R4"; return {1'b1, (e2 & c[5]) ? 2'd2 : 2'd1}; end
      if (e2 & (c[4] | c[5] | c[3] | c[2])) begin tag = "R5"; return 3'b110; end
    end
    if (l == 2'd1) begin
      if (e2 & ((fg & c[4]) | c[3] | c[2])) begin tag = "R6"; return 3'b110; end
    end
    return l3hit ? 3'b111 : 3'b000;
  endfunction

  task automatic op(input logic wr, input logic [63:0] d, input logic [1:0] l,
                    input logic h, input logic [9:0] c, input logic rd,
                    input string force_tag);
    exp_t  e;
    string tg;
    logic [2:0] r;
    @(negedge clk);
    core_wr_en = wr; core_wr_data = d; core_lvl = l; core_halted = h;
    cfgv = c; dbg_rd_en = rd;
    r = ref_trap(h, l, c, tg);
    if (!wr) r = 3'b000;
    if (wr && !r[2]) begin m_data = d[31:0]; m_full = 1'b1; end
    else if (rd) m_full = 1'b0;
    e.vld = r[2]; e.lvl = r[2] ? r[1:0] : 2'd0;
    e.data = {32'h0, m_data}; e.full = m_full;
    e.tag = (force_tag != "") ? force_tag : tg;
    q.push_back(e);
  endtask

  // Monitor
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      @(negedge clk);
      e = q.pop_front();
      n_chk++;
      if (trap_vld !== e.vld || trap_lvl !== e.lvl ||
          trap_class !== (e.vld ? 6'h18 : 6'h00) ||
          dbg_rd_data !== e.data || tx_full !== e.full) begin
        n_err++;
        $display("FAIL %s: got vld=%0b lvl=%0d cls=%h data=%h full=%0b exp vld=%0b lvl=%0d data=%h full=%0b",
                 e.tag, trap_vld, trap_lvl, trap_class, dbg_rd_data, tx_full,
                 e.vld, e.lvl, e.data, e.full);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; core_wr_en = 0; core_wr_data = '0; core_lvl = 0;
    core_halted = 0; cfgv = '0; dbg_rd_en = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    n_chk++;
    if (tx_full !== 1'b0 || dbg_rd_data !== 64'h0 || trap_vld !== 1'b0) begin
      n_err++;
      $display("FAIL R1: got full=%0b data=%h vld=%0b exp 0 0 0", tx_full, dbg_rd_data, trap_vld);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: after release
    n_chk++;
    if (tx_full !== 1'b0 || dbg_rd_data !== 64'h0 || trap_vld !== 1'b0) begin
      n_err++;
      $display("FAIL R1: got full=%0b data=%h vld=%0b exp 0 0 0", tx_full, dbg_rd_data, trap_vld);
    end
    // R2: upper bits dropped
    op(1, 64'hDEADBEEF_12345678, 2'd3, 0, 10'h3FF, 0, "R2");
    // R10: read clears, data kept
    op(0, '0, 2'd0, 0, '0, 1, "R10");
    op(0, '0, 2'd0, 0, '0, 0, "R10");
    // R11: write and read together
    op(1, 64'h0000_0000_A5A5_0F0F, 2'd2, 0, '0, 1, "R11");
    // R9: trapped write, data and full unchanged
    op(1, 64'h1111_2222_3333_4444, 2'd0, 0, 10'b0001000000, 0, "R9");
    op(0, '0, 2'd0, 0, '0, 0, "R9");
    // R6: host redirect ignored at level 1
    op(1, 64'h55, 2'd1, 0, 10'b1001100000, 0, "R6");
    // R7: level-3 channel trap needs fine-grained traps
    op(1, 64'h66, 2'd2, 0, 10'b0100000010, 0, "R7");
    op(1, 64'h77, 2'd2, 0, 10'b0110000010, 0, "R7");
    // Exhaustive sweep of trap settings, levels, halted
    for (int c = 0; c < 1024; c++) begin
      for (int l = 0; l < 4; l++) begin
        for (int h = 0; h < 2; h++) begin
          op(1, {$urandom(), $urandom()}, l[1:0], h[0], c[9:0],
             (c[3:0] == 4'd5) && (l == 1), "");
        end
      end
      if (c[5:0] == 6'd0) op(0, '0, 2'd0, 0, '0, 1, "R10");
    end
    op(0, '0, 2'd0, 0, '0, 0, "R10");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule